// File: doc/BRIEF.md
# Auto-Reload Countdown Timer

This block is a 32-bit down-counter that steps once for every time-base tick it is given. Software can load the count directly at any time and can hold a separate reload value in its own register. When the count steps from one to zero, the block records the event in a sticky status flag. If auto-reload is on and the reload value is nonzero, the count restarts from that value instead of landing on zero.

A reload value of zero never restarts the count. The counter then rests at zero and does not raise a new expiry on every following tick. The status flag stays set until software clears it with a write-one-to-clear strobe. The interrupt output is a level that is high while both the flag and the interrupt enable are set.

The enables are plain inputs driven by the surrounding control register. The block does not decode that register, and it does not contain the time base.

Top module: `countdown_unit`

## Requirements
- R1: After a synchronous active-low reset, the count, the reload value and the status flag are all zero, and `irq_out` is low.
- R2: A count write (`cnt_wr`) loads `cnt_wdata` into the count on the next edge. It takes priority over any decrement, reload or expiry in the same cycle, so an overlapping tick at a count of 1 raises no expiry.
- R3: A tick with a count above 1 lowers the count by exactly one. Without a tick or a write, the count holds.
- R4: A tick while the count is 1 is an expiry: the status flag reads 1 from the next cycle on.
- R5: On an expiry with `rld_en` high and a nonzero reload value, the count takes the reload value on that same edge instead of zero.
- R6: On an expiry with `rld_en` low or a reload value of zero, the count becomes 0. Further ticks at zero leave the count at 0 and raise no expiry, so a cleared flag stays clear.
- R7: A reload write (`rld_wr`) never changes the current count; the new value is used from the next expiry on. An expiry in the same cycle as a reload write uses the value held before that write.
- R8: The status flag is sticky. It is cleared by a `stat_clr_wr` strobe whose data has bit 27 set; other data bits have no effect. An expiry in the same cycle as a clear wins, and the flag stays set.
- R9: `irq_out` is high exactly while the status flag and `irq_en` are both high, with no register delay from `irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Time-base tick enable, one count step per high cycle |
| cnt_wr | input | 1 | Count write strobe |
| cnt_wdata | input | 32 | Count write data |
| rld_wr | input | 1 | Reload value write strobe |
| rld_wdata | input | 32 | Reload value write data |
| rld_en | input | 1 | Auto-reload enable |
| irq_en | input | 1 | Interrupt enable |
| stat_clr_wr | input | 1 | Status write-one-to-clear strobe |
| stat_clr_data | input | 32 | Status clear data, bit 27 clears the flag |
| count | output | 32 | Current count |
| status | output | 1 | Sticky expiry flag |
| irq_out | output | 1 | Level interrupt |

## Verification
The assertions check every single-cycle rule on every cycle:
- write priority, decrement, hold and rest at zero;
- the reload choice on expiry;
- setting the flag on expiry, stickiness and clearing;
- the interrupt gating.

Some behaviour only shows across sequences, and the bench's directed scenarios cover it against its reference model:
- the full count down to expiry;
- a reload value that stays dormant until a later expiry;
- overlapping write-and-tick cycles;
- set-versus-clear collisions.

// File: rtl/cdu_pkg.sv
// Package: shared types for the countdown unit.
// Assumes: nothing; pure type definitions.
package cdu_pkg;
    // Action the count register takes in a cycle, in priority order.
    typedef enum logic [2:0] {
        ACT_HOLD   = 3'd0,
        ACT_LOAD   = 3'd1,
        ACT_DEC    = 3'd2,
        ACT_RELOAD = 3'd3,
        ACT_REST   = 3'd4
    } cnt_act_e;
endpackage

// File: rtl/cdu_reload_reg.sv
// Module: holds the auto-reload value written by software.
// Assumes: the write strobe is a single-cycle pulse; the value is only
// consumed by the count core on an expiry.
module cdu_reload_reg #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] value,
    output logic             value_nz
);
    // Capture the reload value on its own strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (wr) begin
            value <= wdata;
        end
    end

    // Flag a usable (nonzero) reload value.
    always_comb value_nz = |value;
endmodule

// File: rtl/cdu_count_core.sv
// Module: the down-counter; picks one action per cycle and reports expiry.
// Assumes: tick is a one-cycle enable at time-base rate; software write
// outranks counting; expiry is the 1 -> 0 step taken on a tick.
module cdu_count_core
    import cdu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             rld_en,
    input  logic [WIDTH-1:0] rld_value,
    input  logic             rld_nz,
    output logic [WIDTH-1:0] count,
    output logic             expire
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    cnt_act_e   act;
    logic       at_zero;
    logic       at_one;

    // Decode the count value for the action choice.
    always_comb begin
        at_zero = (count == '0);
        at_one  = (count == ONE);
    end

    // Choose the action for this cycle, write first.
    always_comb begin
        if (wr) begin
            act = ACT_LOAD;
        end else if (!tick || at_zero) begin
            act = ACT_HOLD;
        end else if (!at_one) begin
            act = ACT_DEC;
        end else if (rld_en && rld_nz) begin
            act = ACT_RELOAD;
        end else begin
            act = ACT_REST;
        end
    end

    // Report an expiry whenever the step from one is taken.
    always_comb expire = (act == ACT_RELOAD) || (act == ACT_REST);

    // Apply the chosen action to the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            unique case (act)
                ACT_LOAD:   count <= wdata;
                ACT_DEC:    count <= count - ONE;
                ACT_RELOAD: count <= rld_value;
                ACT_REST:   count <= '0;
                default:    count <= count;
            endcase
        end
    end
endmodule

// File: rtl/cdu_status_flag.sv
// Module: sticky expiry flag with write-one-to-clear and interrupt gating.
// Assumes: set_evt is a one-cycle pulse; a set outranks a clear in the
// same cycle so no event is lost.
module cdu_status_flag #(
    parameter int CLR_WIDTH = 32,
    parameter int CLR_BIT   = 27
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_evt,
    input  logic                 clr_wr,
    input  logic [CLR_WIDTH-1:0] clr_data,
    input  logic                 irq_en,
    output logic                 status,
    output logic                 irq
);
    logic clr_hit;

    // Only the designated data bit clears the flag.
    always_comb clr_hit = clr_wr && clr_data[CLR_BIT];

    // Hold the sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= 1'b0;
        end else if (set_evt) begin
            status <= 1'b1;
        end else if (clr_hit) begin
            status <= 1'b0;
        end
    end

    // Gate the level interrupt with its enable.
    always_comb irq = status & irq_en;
endmodule

// File: rtl/countdown_unit.sv
// Module: top of the auto-reload countdown timer.
// Assumes: enables come from an external control register; tick comes
// from the time base; all strobes are synchronous to clk.
module countdown_unit #(
    parameter int WIDTH   = 32,
    parameter int CLR_BIT = 27
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cnt_wr,
    input  logic [WIDTH-1:0] cnt_wdata,
    input  logic             rld_wr,
    input  logic [WIDTH-1:0] rld_wdata,
    input  logic             rld_en,
    input  logic             irq_en,
    input  logic             stat_clr_wr,
    input  logic [WIDTH-1:0] stat_clr_data,
    output logic [WIDTH-1:0] count,
    output logic             status,
    output logic             irq_out
);
    logic [WIDTH-1:0] rld_q;
    logic             rld_nz;
    logic             expire;

    cdu_reload_reg #(.WIDTH(WIDTH)) u_rld (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (rld_wr),
        .wdata    (rld_wdata),
        .value    (rld_q),
        .value_nz (rld_nz)
    );

    cdu_count_core #(.WIDTH(WIDTH)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .wr        (cnt_wr),
        .wdata     (cnt_wdata),
        .rld_en    (rld_en),
        .rld_value (rld_q),
        .rld_nz    (rld_nz),
        .count     (count),
        .expire    (expire)
    );

    cdu_status_flag #(.CLR_WIDTH(WIDTH), .CLR_BIT(CLR_BIT)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_evt  (expire),
        .clr_wr   (stat_clr_wr),
        .clr_data (stat_clr_data),
        .irq_en   (irq_en),
        .status   (status),
        .irq      (irq_out)
    );
endmodule

// File: rtl/countdown_unit_chk.sv
// Module: property checker for countdown_unit, attached by bind.
// Assumes: it sees the top ports plus the held reload value.
module countdown_unit_chk #(
    parameter int WIDTH   = 32,
    parameter int CLR_BIT = 27
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             cnt_wr,
    input logic [WIDTH-1:0] cnt_wdata,
    input logic             rld_en,
    input logic             irq_en,
    input logic             stat_clr_wr,
    input logic [WIDTH-1:0] stat_clr_data,
    input logic [WIDTH-1:0] count,
    input logic             status,
    input logic             irq_out,
    input logic [WIDTH-1:0] rld_q
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    // R2
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> count == $past(cnt_wdata));
    // R3
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && count > ONE) |=> count == $past(count) - ONE);
    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr) |=> $stable(count));
    // R4
    expiry_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && count == ONE) |=> status);
    // R5
    reload_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && count == ONE && rld_en && rld_q != '0)
        |=> count == $past(rld_q));
    // R6
    rest_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && count == ONE && (!rld_en || rld_q == '0))
        |=> count == '0);
    // R6
    zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr && count == '0 && !status) |=> (count == '0 && !status));
    // R8
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status && !(stat_clr_wr && stat_clr_data[CLR_BIT])) |=> status);
    // R8
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr_wr && stat_clr_data[CLR_BIT] && !(tick && !cnt_wr && count == ONE))
        |=> !status);
    // R9
    irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (status && irq_en));
    // R9
    irq_when_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status && irq_en) |-> irq_out);
endmodule

bind countdown_unit countdown_unit_chk #(.WIDTH(WIDTH), .CLR_BIT(CLR_BIT)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick          (tick),
    .cnt_wr        (cnt_wr),
    .cnt_wdata     (cnt_wdata),
    .rld_en        (rld_en),
    .irq_en        (irq_en),
    .stat_clr_wr   (stat_clr_wr),
    .stat_clr_data (stat_clr_data),
    .count         (count),
    .status        (status),
    .irq_out       (irq_out),
    .rld_q         (rld_q)
);

// File: tb/tb_countdown_unit.sv
// Bench: behavioural reference model compared on every clock, plus
// directed scenarios for each requirement and a random mix.
module tb_countdown_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        cnt_wr = 1'b0;
    logic [31:0] cnt_wdata = '0;
    logic        rld_wr = 1'b0;
    logic [31:0] rld_wdata = '0;
    logic        rld_en = 1'b0;
    logic        irq_en = 1'b0;
    logic        stat_clr_wr = 1'b0;
    logic [31:0] stat_clr_data = '0;
    logic [31:0] count;
    logic        status;
    logic        irq_out;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    string cur_req = "R1";

    // reference model state
    longint m_cnt = 0;
    longint m_rld = 0;
    bit     m_st = 0;

    always #4 clk = ~clk;

    countdown_unit dut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .rld_wr(rld_wr), .rld_wdata(rld_wdata),
        .rld_en(rld_en), .irq_en(irq_en),
        .stat_clr_wr(stat_clr_wr), .stat_clr_data(stat_clr_data),
        .count(count), .status(status), .irq_out(irq_out)
    );

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reference model: behaviour taken from the requirements.
    always @(posedge clk) begin
        longint oc;
        longint orl;
        bit exp_evt;
        oc = m_cnt;
        orl = m_rld;
        exp_evt = 0;
        if (!rst_n) begin
            m_cnt = 0; m_rld = 0; m_st = 0;
        end else begin
            if (cnt_wr) m_cnt = cnt_wdata;
            else if (tick && oc != 0) begin
                if (oc == 1) begin
                    exp_evt = 1;
                    m_cnt = (rld_en && orl != 0) ? orl : 0;
                end else m_cnt = oc - 1;
            end
            if (rld_wr) m_rld = rld_wdata;
            if (exp_evt) m_st = 1;
            else if (stat_clr_wr && stat_clr_data[27]) m_st = 0;
        end
    end

    // Compare every cycle away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(cur_req, "count", count, m_cnt);
            chk(cur_req, "status", status, m_st);
            chk(cur_req, "irq_out", irq_out, m_st && irq_en);
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
        end
    end

    task automatic drive_idle();
        tick = 0; cnt_wr = 0; rld_wr = 0; stat_clr_wr = 0; stat_clr_data = '0;
    endtask

    // Wait one edge, then settle inputs for the next one.
    task automatic step();
        @(posedge clk); #1; drive_idle();
    endtask

    task automatic wr_cnt(input logic [31:0] v);
        cnt_wr = 1; cnt_wdata = v; step();
    endtask

    task automatic wr_rld(input logic [31:0] v);
        rld_wr = 1; rld_wdata = v; step();
    endtask

    task automatic clr(input logic [31:0] d);
        stat_clr_wr = 1; stat_clr_data = d; step();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin tick = 1; step(); end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1; rst_n = 1;
        #2;
        // R1 reset state
        cur_req = "R1";
        chk("R1", "count", count, 0);
        chk("R1", "status", status, 0);
        chk("R1", "irq_out", irq_out, 0);
        ticks(3);
        chk("R1", "count after ticks from reset", count, 0);

        // R2 write, R3 decrement and hold
        cur_req = "R2";
        wr_cnt(32'd5);
        chk("R2", "count loaded", count, 5);
        cur_req = "R3";
        ticks(2);
        chk("R3", "count after 2 ticks", count, 3);
        step(); step();
        chk("R3", "count held", count, 3);

        // R4 expiry and R6 rest, R9 irq
        cur_req = "R4";
        irq_en = 1;
        ticks(3);
        chk("R4", "status after expiry", status, 1);
        chk("R6", "count rests", count, 0);
        chk("R9", "irq with enable", irq_out, 1);
        cur_req = "R9";
        irq_en = 0; #1;
        chk("R9", "irq without enable", irq_out, 0);
        irq_en = 1;

        // R8 clear with wrong bit, then right bit
        cur_req = "R8";
        clr(32'hF7FF_FFFF);
        chk("R8", "other bits ignored", status, 1);
        clr(32'h0800_0000);
        chk("R8", "bit 27 clears", status, 0);
        cur_req = "R6";
        ticks(4);
        chk("R6", "no expiry at zero", status, 0);

        // R7 reload write leaves count, R5 reload on expiry
        cur_req = "R7";
        wr_cnt(32'd2);
        wr_rld(32'd7);
        chk("R7", "count untouched by reload write", count, 2);
        rld_en = 1;
        cur_req = "R5";
        ticks(2);
        chk("R5", "reloaded count", count, 7);
        chk("R5", "status on reload expiry", status, 1);
        clr(32'h0800_0000);

        // R2 write overlapping tick at count 1
        cur_req = "R2";
        wr_cnt(32'd1);
        tick = 1; cnt_wr = 1; cnt_wdata = 32'd9; step();
        chk("R2", "write beats expiry count", count, 9);
        chk("R2", "no expiry on overlap", status, 0);

        // R6 reload enabled but value zero
        cur_req = "R6";
        wr_rld(32'd0);
        wr_cnt(32'd1);
        ticks(1);
        chk("R6", "zero reload rests", count, 0);
        clr(32'h0800_0000);
        ticks(5);
        chk("R6", "no retrigger", status, 0);

        // R8 set beats clear
        cur_req = "R8";
        wr_cnt(32'd1);
        tick = 1; stat_clr_wr = 1; stat_clr_data = 32'h0800_0000; step();
        chk("R8", "set wins", status, 1);
        clr(32'h0800_0000);

        // R7 reload write same cycle as expiry uses old value
        cur_req = "R7";
        wr_rld(32'd4);
        wr_cnt(32'd1);
        tick = 1; rld_wr = 1; rld_wdata = 32'd11; step();
        chk("R7", "old reload used", count, 4);
        ticks(4);
        chk("R7", "new reload at next expiry", count, 11);

        // random mix checked by the model
        cur_req = "R3";
        for (int i = 0; i < 3000; i++) begin
            tick = ($urandom_range(0, 3) != 0);
            cnt_wr = ($urandom_range(0, 40) == 0);
            cnt_wdata = $urandom_range(0, 6);
            rld_wr = ($urandom_range(0, 30) == 0);
            rld_wdata = $urandom_range(0, 5);
            rld_en = $urandom_range(0, 1);
            irq_en = $urandom_range(0, 1);
            stat_clr_wr = ($urandom_range(0, 8) == 0);
            stat_clr_data = $urandom_range(0, 1) ? 32'h0800_0000 : 32'h0000_0001;
            @(posedge clk); #1;
        end
        drive_idle();
        step();
        summary();
    end
endmodule